// File: doc/BRIEF.md
# Serial Expansion Channel Controller

This block is the register front end of one channel on a serial expansion port. Software sees five 32-bit registers on a simple write/read bus: status, DMA address, DMA length, control and immediate data. The status register holds interrupt pending flags and their masks, a clock-select field and the chip-select field. A change of chip select is announced to the attached devices as a one-cycle pulse per toggled device.

Writing the control register with its start bit set launches a transfer to the selected device. An immediate transfer moves one to four bytes through the immediate data register over a byte-serial request/acknowledge handshake. A DMA transfer raises a request to an external engine and waits for its done pulse. When a transfer finishes, the start bit drops and the transfer-complete flag rises. A device can ask for delayed completion, and completion then waits for its completion pulse.

The channel number is a parameter. Channel 2 has no insertion interrupt and never reports a present device. Only channel 0 has a writable ROM-disable bit.

Top module: `sxc_channel`

## Requirements
- R1: After reset every register reads 0 (apart from the present bit, which follows its input), `irq` is 0 and neither `imm_req` nor `dma_req` is asserted.
- R2: The pending flags are status bit 0 (expansion), bit 2 (transfer complete) and bit 4 (insertion). Writing 1 to one of them clears it and writing 0 keeps it. A set event in the same cycle as a clearing write wins.
- R3: Status bits 1, 3 and 5 are the masks of bits 0, 2 and 4. Bits [8:6] are the clock select and bits [16+NDEV-1:16] are the chip select. All of these load straight from the written value. `irq` is the OR of each pending flag ANDed with its mask.
- R4: The insertion pending and mask bits change only on channels 0 and 1, and the ROM-disable bit 10 only on channel 0. Status bit 9 reads `dev1_present` except on channel 2, where it reads 0.
- R5: A status write raises `cs_notify` for exactly the next cycle with old XOR new chip select, where bit i stands for device i. `cs_sel` shows the current chip select.
- R6: Control is laid out as [0] start, [1] DMA, [3:2] direction (0 read, 1 write, 2 read-write) and [5:4] byte count minus one. A start with chip select 0 leaves start reading 1, starts no transfer and never sets the transfer-complete flag.
- R7: An immediate transfer moves count+1 bytes, and byte k uses bits [31-8k:24-8k] of the data register. Write mode sends those bytes on `imm_tx`. Read mode stores each acknowledged `imm_rx` in that lane. Read-write mode does both on the same byte.
- R8: A DMA transfer holds `dma_req` until `dma_done`. During it `dma_wr` is 1 for direction 1 and 0 for direction 0, and `dma_addr`/`dma_len` show the DMA address and length registers.
- R9: On the last byte or on `dma_done`, the start bit clears and the transfer-complete flag sets in the same edge. If `dev_delay` is high at that edge, both instead wait for a `dev_cmpl` pulse.
- R10: Direction 3 on an immediate start, or 2 or 3 on a DMA start, clears start, leaves the transfer-complete flag alone and sets the sticky error bit 31 of control. Writing 1 to bit 31 clears that bit.
- R11: While a transfer or a delayed completion is in progress, writes to control, DMA address, DMA length and immediate data have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Byte offset: 0x00 status, 0x04 DMA address, 0x08 DMA length, 0x0C control, 0x10 data |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_exi | input | 1 | Sets the expansion pending flag |
| evt_ins | input | 1 | Sets the insertion pending flag |
| dev1_present | input | 1 | Presence of device 1 |
| cs_sel | output | NDEV | Current chip select |
| cs_notify | output | NDEV | One-cycle pulse of toggled select bits |
| imm_req | output | 1 | Immediate byte request |
| imm_dir | output | 2 | Direction of the immediate transfer |
| imm_tx | output | 8 | Byte sent to the device |
| imm_ack | input | 1 | Device accepts the current byte |
| imm_rx | input | 8 | Byte returned by the device |
| dma_req | output | 1 | DMA request to the external engine |
| dma_wr | output | 1 | DMA direction, 1 = write |
| dma_addr | output | 32 | DMA memory address |
| dma_len | output | 32 | DMA length |
| dma_done | input | 1 | DMA engine finished |
| dev_delay | input | 1 | Device asks for delayed completion |
| dev_cmpl | input | 1 | Delayed completion pulse |
| irq | output | 1 | Masked interrupt |

## Verification
Immediate transfers run in write, read and read-write mode with a device byte that changes on every acknowledge. This separates lane order and lane replacement from a plain fill. The status register sees writes of 0 and of 1 to the pending bits, and a set event arriving on the same edge as a clear, which tells keep, clear and set priority apart. A second instance on channel 2 shares every input, so channel-dependent bits can be compared directly. Starts with no device selected, illegal directions and control writes during DMA each check that the transfer-complete flag stays low where it must.

// File: rtl/sxc_channel.sv
module sxc_channel #(
  parameter int CHAN_ID = 0,
  parameter int NDEV    = 3,
  parameter int AW      = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic            evt_exi,
  input  logic            evt_ins,
  input  logic            dev1_present,
  output logic [NDEV-1:0] cs_sel,
  output logic [NDEV-1:0] cs_notify,
  output logic            imm_req,
  output logic [1:0]      imm_dir,
  output logic [7:0]      imm_tx,
  input  logic            imm_ack,
  input  logic [7:0]      imm_rx,
  output logic            dma_req,
  output logic            dma_wr,
  output logic [31:0]     dma_addr,
  output logic [31:0]     dma_len,
  input  logic            dma_done,
  input  logic            dev_delay,
  input  logic            dev_cmpl,
  output logic            irq
);
  localparam bit HAS_EXT = (CHAN_ID < 2);
  localparam bit HAS_ROM = (CHAN_ID == 0);
  localparam int CS_LSB  = 16;
  localparam logic [AW-1:0] OFS_ST = AW'(5'h00);
  localparam logic [AW-1:0] OFS_DA = AW'(5'h04);
  localparam logic [AW-1:0] OFS_DL = AW'(5'h08);
  localparam logic [AW-1:0] OFS_CT = AW'(5'h0C);
  localparam logic [AW-1:0] OFS_IM = AW'(5'h10);

  typedef enum logic [1:0] {S_IDLE, S_IMM, S_DMA, S_WAIT} xfer_e;

  xfer_e            state;
  logic [1:0]       bcnt;
  logic             exi_p, exi_m, tc_p, tc_m, ext_p, ext_m, rom_d;
  logic [2:0]       clk_s;
  logic [NDEV-1:0]  cs;
  logic [31:0]      dma_a, dma_l, imm_d;
  logic             ctl_start, ctl_dma, ctl_err;
  logic [1:0]       ctl_dir, ctl_len;

  wire idle  = (state == S_IDLE);
  wire wr_st = bus_wr && bus_addr == OFS_ST;
  wire wr_da = bus_wr && bus_addr == OFS_DA && idle;
  wire wr_dl = bus_wr && bus_addr == OFS_DL && idle;
  wire wr_ct = bus_wr && bus_addr == OFS_CT && idle;
  wire wr_im = bus_wr && bus_addr == OFS_IM && idle;
  wire [NDEV-1:0] wcs = bus_wdata[CS_LSB +: NDEV];

  wire launch = wr_ct && bus_wdata[0] && (|cs);
  wire bad    = bus_wdata[1] ? bus_wdata[3] : (bus_wdata[3:2] == 2'b11);
  wire last   = (state == S_IMM && imm_ack && bcnt == ctl_len) ||
                (state == S_DMA && dma_done);
  wire finish = (last && !dev_delay) || (state == S_WAIT && dev_cmpl);
  wire rd_lane = (state == S_IMM) && imm_ack && (ctl_dir != 2'd1);

  assign cs_sel   = cs;
  assign imm_req  = (state == S_IMM);
  assign imm_dir  = ctl_dir;
  assign imm_tx   = imm_d[{~bcnt, 3'b000} +: 8];
  assign dma_req  = (state == S_DMA);
  assign dma_wr   = ctl_dir[0];
  assign dma_addr = dma_a;
  assign dma_len  = dma_l;
  assign irq      = (exi_p & exi_m) | (tc_p & tc_m) | (ext_p & ext_m);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_ST: begin
        bus_rdata[5:0]           = {ext_m, ext_p, tc_m, tc_p, exi_m, exi_p};
        bus_rdata[8:6]           = clk_s;
        bus_rdata[9]             = (CHAN_ID == 2) ? 1'b0 : dev1_present;
        bus_rdata[10]            = rom_d;
        bus_rdata[CS_LSB +: NDEV] = cs;
      end
      OFS_DA:  bus_rdata = dma_a;
      OFS_DL:  bus_rdata = dma_l;
      OFS_CT:  bus_rdata = {ctl_err, 25'd0, ctl_len, ctl_dir, ctl_dma, ctl_start};
      OFS_IM:  bus_rdata = imm_d;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; bcnt <= '0;
      exi_p <= 1'b0; exi_m <= 1'b0; tc_p <= 1'b0; tc_m <= 1'b0;
      ext_p <= 1'b0; ext_m <= 1'b0; rom_d <= 1'b0; clk_s <= '0;
      cs <= '0; cs_notify <= '0;
      dma_a <= '0; dma_l <= '0; imm_d <= '0;
      ctl_start <= 1'b0; ctl_dma <= 1'b0; ctl_err <= 1'b0;
      ctl_dir <= '0; ctl_len <= '0;
    end else begin
      cs_notify <= '0;
      if (evt_exi) exi_p <= 1'b1;
      else if (wr_st && bus_wdata[0]) exi_p <= 1'b0;
      if (finish) tc_p <= 1'b1;
      else if (wr_st && bus_wdata[2]) tc_p <= 1'b0;
      if (HAS_EXT) begin
        if (evt_ins) ext_p <= 1'b1;
        else if (wr_st && bus_wdata[4]) ext_p <= 1'b0;
      end
      if (wr_st) begin
        exi_m <= bus_wdata[1];
        tc_m  <= bus_wdata[3];
        clk_s <= bus_wdata[8:6];
        if (HAS_EXT) ext_m <= bus_wdata[5];
        if (HAS_ROM) rom_d <= bus_wdata[10];
        cs        <= wcs;
        cs_notify <= cs ^ wcs;
      end
      if (wr_da) dma_a <= bus_wdata;
      if (wr_dl) dma_l <= bus_wdata;
      if (wr_im) imm_d <= bus_wdata;
      else if (rd_lane) imm_d[{~bcnt, 3'b000} +: 8] <= imm_rx;

      if (wr_ct) begin
        ctl_start <= bus_wdata[0] && !(launch && bad);
        ctl_dma   <= bus_wdata[1];
        ctl_dir   <= bus_wdata[3:2];
        ctl_len   <= bus_wdata[5:4];
        ctl_err   <= (ctl_err && !bus_wdata[31]) || (launch && bad);
      end else if (finish) begin
        ctl_start <= 1'b0;
      end

      case (state)
        S_IDLE: if (launch && !bad) begin
          state <= bus_wdata[1] ? S_DMA : S_IMM;
          bcnt  <= '0;
        end
        S_IMM: if (imm_ack) begin
          bcnt <= bcnt + 2'd1;
          if (bcnt == ctl_len) state <= dev_delay ? S_WAIT : S_IDLE;
        end
        S_DMA:  if (dma_done) state <= dev_delay ? S_WAIT : S_IDLE;
        S_WAIT: if (dev_cmpl) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_one_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(imm_req && dma_req));
  p_dma_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_done) |=> dma_req);
  p_tc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && bus_wdata[2] && !finish) |=> !tc_p);
  p_complete_r9: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (tc_p && !ctl_start && idle));
  p_notify_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|cs_notify) |-> $past(wr_st));
  p_illegal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && bad) |=> (ctl_err && !ctl_start && idle));
  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && bus_wr && bus_addr == OFS_CT) |=> $stable({ctl_dma, ctl_dir, ctl_len}));
endmodule

// File: tb/sxc_channel_tb.sv
module sxc_channel_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        bus_wr = 0;
  logic [4:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic        evt_exi = 0, evt_ins = 0, dev1_present = 0;
  logic        imm_ack = 0, dma_done = 0, dev_delay = 0, dev_cmpl = 0;
  logic [7:0]  imm_rx = 0;
  logic [31:0] rdata, rdata2;
  logic [2:0]  cs_sel, cs_notify, cs_sel2, cs_notify2;
  logic        imm_req, dma_req, dma_wr, irq, imm_req2, dma_req2, dma_wr2, irq2;
  logic [1:0]  imm_dir, imm_dir2;
  logic [7:0]  imm_tx, imm_tx2;
  logic [31:0] dma_addr, dma_len, dma_addr2, dma_len2;

  sxc_channel #(.CHAN_ID(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata), .evt_exi(evt_exi), .evt_ins(evt_ins), .dev1_present(dev1_present),
    .cs_sel(cs_sel), .cs_notify(cs_notify), .imm_req(imm_req), .imm_dir(imm_dir),
    .imm_tx(imm_tx), .imm_ack(imm_ack), .imm_rx(imm_rx), .dma_req(dma_req), .dma_wr(dma_wr),
    .dma_addr(dma_addr), .dma_len(dma_len), .dma_done(dma_done), .dev_delay(dev_delay),
    .dev_cmpl(dev_cmpl), .irq(irq));

  sxc_channel #(.CHAN_ID(2)) u_ch2 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata2), .evt_exi(evt_exi), .evt_ins(evt_ins), .dev1_present(dev1_present),
    .cs_sel(cs_sel2), .cs_notify(cs_notify2), .imm_req(imm_req2), .imm_dir(imm_dir2),
    .imm_tx(imm_tx2), .imm_ack(imm_ack), .imm_rx(imm_rx), .dma_req(dma_req2), .dma_wr(dma_wr2),
    .dma_addr(dma_addr2), .dma_len(dma_len2), .dma_done(dma_done), .dev_delay(dev_delay),
    .dev_cmpl(dev_cmpl), .irq(irq2));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model of channel 0
  bit        mv = 0;
  bit        m_exi_p, m_exi_m, m_tc_p, m_tc_m, m_ext_p, m_ext_m, m_rom;
  bit [2:0]  m_clk, m_cs, m_ntf;
  bit [31:0] m_da, m_dl, m_imm;
  bit        m_st, m_dma, m_err;
  bit [1:0]  m_dir, m_lenf;
  int        ph, k;

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_exi_p, m_exi_m, m_tc_p, m_tc_m, m_ext_p, m_ext_m, m_rom} = '0;
      m_clk = 0; m_cs = 0; m_ntf = 0; m_da = 0; m_dl = 0; m_imm = 0;
      m_st = 0; m_dma = 0; m_err = 0; m_dir = 0; m_lenf = 0; ph = 0; k = 0; mv = 1;
    end else begin
      automatic bit fin = 0;
      automatic int nph = ph;
      automatic bit wst = bus_wr && bus_addr == 5'h00;
      automatic bit idle_now = (ph == 0);
      if (ph == 1 && imm_ack) begin
        if (m_dir != 2'd1) m_imm[31 - 8*k -: 8] = imm_rx;
        if (k == int'(m_lenf)) begin fin = !dev_delay; nph = dev_delay ? 3 : 0; end
        else k = k + 1;
      end else if (ph == 2 && dma_done) begin
        fin = !dev_delay; nph = dev_delay ? 3 : 0;
      end else if (ph == 3 && dev_cmpl) begin
        fin = 1; nph = 0;
      end
      m_exi_p = evt_exi | (m_exi_p & !(wst & bus_wdata[0]));
      m_tc_p  = fin     | (m_tc_p  & !(wst & bus_wdata[2]));
      m_ext_p = evt_ins | (m_ext_p & !(wst & bus_wdata[4]));
      m_ntf = 0;
      if (bus_wr && idle_now) begin
        case (bus_addr)
          5'h04: m_da = bus_wdata;
          5'h08: m_dl = bus_wdata;
          5'h10: m_imm = bus_wdata;
          5'h0C: begin
            automatic bit go = bus_wdata[0] && m_cs != 0;
            automatic bit ill = bus_wdata[1] ? bus_wdata[3] : (bus_wdata[3:2] == 2'b11);
            m_dma = bus_wdata[1]; m_dir = bus_wdata[3:2]; m_lenf = bus_wdata[5:4];
            m_st = bus_wdata[0] && !(go && ill);
            m_err = (m_err && !bus_wdata[31]) || (go && ill);
            if (go && !ill) begin nph = bus_wdata[1] ? 2 : 1; k = 0; end
          end
          default: ;
        endcase
      end else if (fin) m_st = 0;
      if (wst) begin
        m_exi_m = bus_wdata[1]; m_tc_m = bus_wdata[3]; m_ext_m = bus_wdata[5];
        m_clk = bus_wdata[8:6]; m_rom = bus_wdata[10];
        m_ntf = m_cs ^ bus_wdata[18:16]; m_cs = bus_wdata[18:16];
      end
      ph = nph;
    end
  end

  function automatic logic [31:0] exp_rd(logic [4:0] a);
    case (a)
      5'h00: return {13'd0, m_cs, 5'd0, m_rom, dev1_present, m_clk,
                     m_ext_m, m_ext_p, m_tc_m, m_tc_p, m_exi_m, m_exi_p};
      5'h04: return m_da;
      5'h08: return m_dl;
      5'h0C: return {m_err, 25'd0, m_lenf, m_dir, m_dma, m_st};
      5'h10: return m_imm;
      default: return 32'd0;
    endcase
  endfunction

  always @(negedge clk) if (rst_n && mv && !done) begin
    check("R3 irq vs model", {31'd0, irq},
          {31'd0, (m_exi_p & m_exi_m) | (m_tc_p & m_tc_m) | (m_ext_p & m_ext_m)});
    check("R2 register readback vs model", rdata, exp_rd(bus_addr));
    check("R5 cs_notify vs model", {29'd0, cs_notify}, {29'd0, m_ntf});
    check("R7 imm_req vs model", {31'd0, imm_req}, {31'd0, ph == 1});
    check("R8 dma_req vs model", {31'd0, dma_req}, {31'd0, ph == 2});
    if (ph == 1) check("R7 imm_tx lane", {24'd0, imm_tx}, {24'd0, m_imm[31 - 8*k -: 8]});
    if (ph == 2) begin
      check("R8 dma_wr", {31'd0, dma_wr}, {31'd0, m_dir == 2'd1});
      check("R8 dma_addr", dma_addr, m_da);
    end
  end

  task automatic step();
    @(posedge clk); #2;
    if (imm_req) imm_rx = imm_rx + 8'h11;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; step(); bus_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v, output logic [31:0] v2);
    bus_addr = a; #1; v = rdata; v2 = rdata2;
  endtask

  task automatic wait_tc();
    logic [31:0] v, v2;
    for (int i = 0; i < 30; i++) begin
      rd(5'h00, v, v2);
      if (v[2]) break;
      step();
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  localparam logic [31:0] S = 32'h0000_042A;
  localparam logic [31:0] CS1 = 32'h0001_0000;

  initial begin
    logic [31:0] v, v2;
    repeat (3) step();
    rst_n = 1; step();
    // R1 reset state
    rd(5'h00, v, v2); check("R1 status after reset", v, 0);
    rd(5'h0C, v, v2); check("R1 control after reset", v, 0);
    rd(5'h10, v, v2); check("R1 data after reset", v, 0);
    check("R1 irq and requests idle", {irq, imm_req, dma_req}, 0);
    // R4 presence
    dev1_present = 1; step();
    rd(5'h00, v, v2);
    check("R4 present bit ch0", v, 32'h200); check("R4 present bit ch2", v2, 0);
    // R2/R3 pending and masks
    evt_exi = 1; evt_ins = 1; step(); evt_exi = 0; evt_ins = 0;
    rd(5'h00, v, v2); check("R2 events set ch0", v, 32'h211); check("R4 insertion ignored ch2", v2, 1);
    wr(5'h00, 32'h2A);
    rd(5'h00, v, v2); check("R3 masks loaded", v, 32'h23B); check("R3 irq on", {31'd0, irq}, 1);
    wr(5'h00, 32'h2A);
    rd(5'h00, v, v2); check("R2 write 0 keeps pending", v, 32'h23B);
    wr(5'h00, 32'h2B);
    rd(5'h00, v, v2); check("R2 w1c expansion", v, 32'h23A); check("R3 irq by insertion", {31'd0, irq}, 1);
    wr(5'h00, 32'h3B);
    rd(5'h00, v, v2); check("R2 w1c insertion", v, 32'h22A); check("R3 irq off", {31'd0, irq}, 0);
    check("R4 ext mask ignored ch2", v2, 32'h00A);
    evt_exi = 1; wr(5'h00, 32'h2B); evt_exi = 0;
    rd(5'h00, v, v2); check("R2 set beats clear", v, 32'h22B);
    wr(5'h00, 32'h2B);
    wr(5'h00, S | 32'h1C0);
    rd(5'h00, v, v2); check("R4 rom bit ch0 and clock select", v, 32'h7EA); check("R4 rom ignored ch2", v2, 32'h1CA);
    // R5 chip select notification
    wr(5'h00, S | CS1);
    check("R5 notify first select", {29'd0, cs_notify}, 1); check("R5 cs_sel", {29'd0, cs_sel}, 1);
    step(); check("R5 notify one cycle", {29'd0, cs_notify}, 0);
    wr(5'h00, S | 32'h0004_0000); check("R5 notify toggled bits", {29'd0, cs_notify}, 5);
    wr(5'h00, S);                 check("R5 notify on deselect", {29'd0, cs_notify}, 4);
    // R6 start without device
    wr(5'h0C, 32'h1); repeat (4) step();
    rd(5'h0C, v, v2); check("R6 start stays set", v, 1);
    rd(5'h00, v, v2); check("R6 no completion", {31'd0, v[2]}, 0);
    check("R6 no request", {imm_req, dma_req}, 0);
    wr(5'h0C, 32'h0);
    // R7 immediate write, read, read-write
    wr(5'h00, S | CS1); imm_ack = 1;
    wr(5'h10, 32'hA1B2C3D4); wr(5'h0C, 32'h15); wait_tc();
    rd(5'h10, v, v2); check("R7 write keeps data", v, 32'hA1B2C3D4);
    rd(5'h0C, v, v2); check("R9 start cleared", v, 32'h14);
    check("R9 irq from completion", {31'd0, irq}, 1);
    wr(5'h00, S | CS1 | 32'h4);
    imm_rx = 0; wr(5'h0C, 32'h11); wait_tc();
    rd(5'h10, v, v2); check("R7 read lanes in order", v, 32'h1122C3D4);
    wr(5'h00, S | CS1 | 32'h4);
    imm_rx = 8'h40; wr(5'h0C, 32'h09); wait_tc();
    rd(5'h10, v, v2); check("R7 read-write lane", v, 32'h5122C3D4);
    wr(5'h00, S | CS1 | 32'h4);
    // R9 delayed completion
    dev_delay = 1; wr(5'h0C, 32'h05); repeat (3) step();
    rd(5'h00, v, v2); check("R9 delayed no flag", {31'd0, v[2]}, 0);
    rd(5'h0C, v, v2); check("R9 delayed start held", v, 32'h05);
    dev_delay = 0; dev_cmpl = 1; step(); dev_cmpl = 0;
    rd(5'h00, v, v2); check("R9 flag after device pulse", {31'd0, v[2]}, 1);
    rd(5'h0C, v, v2); check("R9 start cleared after pulse", v, 32'h04);
    wr(5'h00, S | CS1 | 32'h4);
    // R8 DMA and R11 busy writes
    wr(5'h04, 32'h1000); wr(5'h08, 32'h40); wr(5'h0C, 32'h07);
    check("R8 dma request", {dma_req, dma_wr}, 2'b11);
    check("R8 dma length", dma_len, 32'h40);
    wr(5'h0C, 32'h0); wr(5'h10, 32'hDEAD); wr(5'h04, 32'h2000); step();
    rd(5'h0C, v, v2); check("R11 control write ignored", v, 32'h07);
    rd(5'h10, v, v2); check("R11 data write ignored", v, 32'h5122C3D4);
    check("R11 address write ignored", dma_addr, 32'h1000);
    check("R8 request held", {31'd0, dma_req}, 1);
    dma_done = 1; step(); dma_done = 0;
    rd(5'h00, v, v2); check("R9 dma completion flag", {31'd0, v[2]}, 1);
    check("R8 request dropped", {31'd0, dma_req}, 0);
    wr(5'h00, S | CS1 | 32'h4);
    wr(5'h0C, 32'h03); check("R8 dma read direction", {dma_req, dma_wr}, 2'b10);
    dma_done = 1; step(); dma_done = 0;
    wr(5'h00, S | CS1 | 32'h4);
    // R10 illegal directions
    wr(5'h0C, 32'h0B);
    rd(5'h0C, v, v2); check("R10 dma read-write rejected", v, 32'h8000000A);
    rd(5'h00, v, v2); check("R10 no completion", {31'd0, v[2]}, 0);
    check("R10 no request", {imm_req, dma_req}, 0);
    wr(5'h0C, 32'h8000_0000);
    rd(5'h0C, v, v2); check("R10 error cleared", v, 0);
    wr(5'h0C, 32'h0D); step();
    rd(5'h0C, v, v2); check("R10 immediate code 3 rejected", v, 32'h8000000C);
    rd(5'h00, v, v2); check("R10 no completion imm", {31'd0, v[2]}, 0);
    wr(5'h0C, 32'h0); rd(5'h0C, v, v2); check("R10 error sticky", v, 32'h80000000);
    repeat (3) step();
    finish_run();
  end
endmodule